// File: doc/BRIEF.md
# Cascadable Serial Register Write Port

This block receives 16-bit command words over a three-wire serial link: a data input, a shift clock and a load strobe. Bits enter a 16-bit shift register, most significant bit first, one per rising shift-clock edge. The bit that leaves the top of the register appears on a serial data output. That output can feed the data input of the next device, so several devices form one long shift chain. All devices in the chain share the shift clock and the load strobe.

On a rising load edge, every device decodes its own word at the same moment. Word bits 11:8 are the register address, bits 7:0 are the data, and bits 15:12 are ignored. The register file holds eight digit registers, six control registers and one feature register. Address 0 is a no-op. To write device k of a chain, shift its command first and then one no-op for every device that sits before it in the chain. The other devices then latch no-ops and stay unchanged. The feature register is decoded into individual enable outputs. Its reset bit returns the control registers to their power-up values and leaves the digit data alone.

The serial pins are sampled by the system clock `clk`. Edges of the shift clock and the load strobe are found by comparing each pin with its value one cycle earlier.

Top module: `ser_reg_port`

## Requirements
- R1: After reset the digit registers read 0x00 and the feature register reads 0x00. The control registers read their defaults: index 2 (address 0xB) is 0x07 and all others are 0x00. The serial output is 0.
- R2: Each rising shift-clock edge moves the register up one place and loads the data input into bit 0. The serial output shows bit 15 of the register and changes only on a rising shift-clock edge.
- R3: On a rising load edge, word bits 11:8 select the register and bits 7:0 give its value. Bits 15:12 have no effect. Addresses 0x1 to 0x8 write digit registers 0 to 7 (`digits_o[8k+:8]`).
- R4: Addresses 0x9, 0xA, 0xB, 0xC and 0xD write control registers 0 to 4, and address 0xF writes control register 5 (`ctrl_o[8i+:8]`).
- R5: A word with address 0x0 changes no register, whatever its data bits are.
- R6: Address 0xE writes the feature register. Bit 0 drives `ext_clk_en_o`. Bit 2 drives `hex_decode_o` (0 selects Code-B, 1 selects hexadecimal). Bit 4 drives `blink_en_o`, bit 5 drives `blink_slow_o`, bit 6 drives `blink_sync_o` and bit 7 drives `blink_start_on_o`.
- R7: Feature bit 3 always reads 0. Feature bit 1 reads 0 after every write, because it clears itself.
- R8: A feature write with bit 1 set returns all six control registers to their R1 defaults in the same load. The feature register still takes the other written bits, and the digit registers keep their contents.
- R9: In a two-device chain, shifting a command and then a no-op, followed by one load, updates only the far device. The near device is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_i | input | 1 | Serial shift clock (level, sampled) |
| sdin_i | input | 1 | Serial data input |
| load_i | input | 1 | Load strobe; rising edge applies the word |
| sdout_o | output | 1 | Bit 15 of the shift register, to the next device |
| digits_o | output | 64 | Eight digit registers, digit k at bits 8k+7:8k |
| ctrl_o | output | 48 | Six control registers, index i at bits 8i+7:8i |
| feature_o | output | 8 | Feature register contents |
| ext_clk_en_o | output | 1 | External system clock select |
| hex_decode_o | output | 1 | 1 = hexadecimal decode, 0 = Code-B |
| blink_en_o | output | 1 | Blinking enabled |
| blink_slow_o | output | 1 | Slow blink rate selected |
| blink_sync_o | output | 1 | Blink timing synchronised to load |
| blink_start_on_o | output | 1 | Blinking starts in the lit phase |

## Verification
The assertions assume that the serial pins change relative to `clk` and that each level of the shift clock and the load strobe is held for at least one system-clock cycle. They also assume that a load rise never lands in the same cycle as a shift-clock rise, so a word is complete before it is applied. The stimulus changes pins only on the falling system-clock edge and holds each level for two cycles. It raises the load strobe only after the last shift-clock pulse of a word has ended. Random words cover every address, including no-ops and feature writes with the reset bit set. They are shifted through two chained instances.

// File: rtl/srp_pkg.sv
package srp_pkg;

    localparam int WORD_W    = 16;
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 8;
    localparam int NUM_DIG   = 8;
    localparam int NUM_CTRL  = 6;
    localparam int DIG_IW    = $clog2(NUM_DIG);
    localparam int CTRL_IW   = $clog2(NUM_CTRL);

    localparam logic [ADDR_W-1:0] ADDR_NOP  = 4'h0;
    localparam logic [ADDR_W-1:0] ADDR_FEAT = 4'hE;

    // feature bit positions
    localparam int FB_EXTCLK = 0;
    localparam int FB_REGRES = 1;
    localparam int FB_HEX    = 2;
    localparam int FB_UNUSED = 3;
    localparam int FB_BLINK  = 4;
    localparam int FB_SLOW   = 5;
    localparam int FB_SYNC   = 6;
    localparam int FB_START  = 7;

    // bits kept when the feature register is written
    localparam logic [DATA_W-1:0] FEAT_KEEP =
        ~((DATA_W'(1) << FB_REGRES) | (DATA_W'(1) << FB_UNUSED));

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_t;

    function automatic logic [ADDR_W-1:0] ctrl_addr(input int idx);
        if (idx < 5) return ADDR_W'(9 + idx);
        return 4'hF;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_default(input int idx);
        if (idx == 2) return 8'h07;
        return 8'h00;
    endfunction

endpackage

// File: rtl/srp_shift.sv
module srp_shift
    import srp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic sdin_i,
    input  logic load_i,
    output logic sdout_o,
    output cmd_t cmd_o,
    output logic latch_o
);

    typedef struct packed {
        logic [WORD_W-1:0] sr;
        logic              sclk_prev;
        logic              load_prev;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic      shift_pulse;

    always_comb begin
        st_d          = st_q;
        shift_pulse   = sclk_i & ~st_q.sclk_prev;
        latch_o       = load_i & ~st_q.load_prev;
        st_d.sclk_prev = sclk_i;
        st_d.load_prev = load_i;
        if (shift_pulse)
            st_d.sr = {st_q.sr[WORD_W-2:0], sdin_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdout_o = st_q.sr[WORD_W-1];
    assign cmd_o   = st_q.sr[ADDR_W+DATA_W-1:0];

    assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_pulse |=> st_q.sr[0] == $past(sdin_i));

    assert_sdout_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_pulse |=> $stable(sdout_o));

endmodule

// File: rtl/srp_decode.sv
module srp_decode
    import srp_pkg::*;
(
    input  cmd_t               cmd_i,
    output logic               is_nop_o,
    output logic               is_digit_o,
    output logic               is_ctrl_o,
    output logic               is_feat_o,
    output logic [DIG_IW-1:0]  dig_idx_o,
    output logic [CTRL_IW-1:0] ctrl_idx_o
);

    logic [NUM_CTRL-1:0] ctrl_hit;
    logic [ADDR_W-1:0]   addr_m1;

    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl_match
        assign ctrl_hit[g] = (cmd_i.addr == ctrl_addr(g));
    end

    always_comb begin
        addr_m1    = cmd_i.addr - ADDR_W'(1);
        is_nop_o   = (cmd_i.addr == ADDR_NOP);
        is_feat_o  = (cmd_i.addr == ADDR_FEAT);
        is_digit_o = (int'(cmd_i.addr) >= 1) && (int'(cmd_i.addr) <= NUM_DIG);
        dig_idx_o  = addr_m1[DIG_IW-1:0];
        is_ctrl_o  = |ctrl_hit;
        ctrl_idx_o = '0;
        for (int i = 0; i < NUM_CTRL; i++) begin
            if (ctrl_hit[i]) ctrl_idx_o = CTRL_IW'(i);
        end
    end

endmodule

// File: rtl/srp_regs.sv
module srp_regs
    import srp_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             latch_i,
    input  logic                             is_nop_i,
    input  logic                             is_digit_i,
    input  logic                             is_ctrl_i,
    input  logic                             is_feat_i,
    input  logic [DIG_IW-1:0]                dig_idx_i,
    input  logic [CTRL_IW-1:0]               ctrl_idx_i,
    input  logic [DATA_W-1:0]                data_i,
    output logic [NUM_DIG-1:0][DATA_W-1:0]   dig_o,
    output logic [NUM_CTRL-1:0][DATA_W-1:0]  ctl_o,
    output logic [DATA_W-1:0]                feat_o
);

    typedef struct packed {
        logic [NUM_DIG-1:0][DATA_W-1:0]  dig;
        logic [NUM_CTRL-1:0][DATA_W-1:0] ctl;
        logic [DATA_W-1:0]               feat;
    } regs_st_t;

    function automatic logic [NUM_CTRL-1:0][DATA_W-1:0] ctl_defaults();
        logic [NUM_CTRL-1:0][DATA_W-1:0] v;
        for (int i = 0; i < NUM_CTRL; i++) v[i] = ctrl_default(i);
        return v;
    endfunction

    localparam logic [NUM_CTRL-1:0][DATA_W-1:0] CTL_DEF = ctl_defaults();

    regs_st_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        if (latch_i) begin
            if (is_digit_i) begin
                rg_d.dig[dig_idx_i] = data_i;
            end else if (is_ctrl_i) begin
                rg_d.ctl[ctrl_idx_i] = data_i;
            end else if (is_feat_i) begin
                rg_d.feat = data_i & FEAT_KEEP;
                if (data_i[FB_REGRES]) rg_d.ctl = CTL_DEF;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rg_q.dig  <= '0;
            rg_q.ctl  <= CTL_DEF;
            rg_q.feat <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign dig_o  = rg_q.dig;
    assign ctl_o  = rg_q.ctl;
    assign feat_o = rg_q.feat;

    assert_nop_no_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_i && is_nop_i) |=> ($stable(rg_q.dig) && $stable(rg_q.ctl) && $stable(rg_q.feat)));

    assert_feat_fixed_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_q.feat[FB_UNUSED] == 1'b0) && (rg_q.feat[FB_REGRES] == 1'b0));

    assert_regres_digits_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_i && is_feat_i && data_i[FB_REGRES]) |=> ($stable(rg_q.dig) && rg_q.ctl == CTL_DEF));

endmodule

// File: rtl/ser_reg_port.sv
module ser_reg_port
    import srp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sclk_i,
    input  logic        sdin_i,
    input  logic        load_i,
    output logic        sdout_o,
    output logic [63:0] digits_o,
    output logic [47:0] ctrl_o,
    output logic [7:0]  feature_o,
    output logic        ext_clk_en_o,
    output logic        hex_decode_o,
    output logic        blink_en_o,
    output logic        blink_slow_o,
    output logic        blink_sync_o,
    output logic        blink_start_on_o
);

    cmd_t                             cmd;
    logic                             latch;
    logic                             is_nop, is_digit, is_ctrl, is_feat;
    logic [DIG_IW-1:0]                dig_idx;
    logic [CTRL_IW-1:0]               ctrl_idx;
    logic [NUM_DIG-1:0][DATA_W-1:0]   dig;
    logic [NUM_CTRL-1:0][DATA_W-1:0]  ctl;
    logic [DATA_W-1:0]                feat;

    srp_shift u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_i  (sclk_i),
        .sdin_i  (sdin_i),
        .load_i  (load_i),
        .sdout_o (sdout_o),
        .cmd_o   (cmd),
        .latch_o (latch)
    );

    srp_decode u_dec (
        .cmd_i      (cmd),
        .is_nop_o   (is_nop),
        .is_digit_o (is_digit),
        .is_ctrl_o  (is_ctrl),
        .is_feat_o  (is_feat),
        .dig_idx_o  (dig_idx),
        .ctrl_idx_o (ctrl_idx)
    );

    srp_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .latch_i    (latch),
        .is_nop_i   (is_nop),
        .is_digit_i (is_digit),
        .is_ctrl_i  (is_ctrl),
        .is_feat_i  (is_feat),
        .dig_idx_i  (dig_idx),
        .ctrl_idx_i (ctrl_idx),
        .data_i     (cmd.data),
        .dig_o      (dig),
        .ctl_o      (ctl),
        .feat_o     (feat)
    );

    assign digits_o         = dig;
    assign ctrl_o           = ctl;
    assign feature_o        = feat;
    assign ext_clk_en_o     = feat[FB_EXTCLK];
    assign hex_decode_o     = feat[FB_HEX];
    assign blink_en_o       = feat[FB_BLINK];
    assign blink_slow_o     = feat[FB_SLOW];
    assign blink_sync_o     = feat[FB_SYNC];
    assign blink_start_on_o = feat[FB_START];

    assert_decode_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({is_nop, is_digit, is_ctrl, is_feat}));

    assert_latch_writes_digit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (latch && is_digit) |=> (digits_o[8*$past(dig_idx) +: 8] == $past(cmd.data)));

endmodule

// File: tb/sim_ser_reg_port.sv
module sim_ser_reg_port;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, sclk, sdin, load;
    logic        sd0, sd1;
    logic [63:0] dg0, dg1;
    logic [47:0] ct0, ct1;
    logic [7:0]  ft0, ft1;
    logic [5:0]  fl0, fl1;

    int errors = 0;
    int checks = 0;

    ser_reg_port u0 (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdin_i(sdin), .load_i(load),
        .sdout_o(sd0), .digits_o(dg0), .ctrl_o(ct0), .feature_o(ft0),
        .ext_clk_en_o(fl0[0]), .hex_decode_o(fl0[1]), .blink_en_o(fl0[2]),
        .blink_slow_o(fl0[3]), .blink_sync_o(fl0[4]), .blink_start_on_o(fl0[5])
    );

    ser_reg_port u1 (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdin_i(sd0), .load_i(load),
        .sdout_o(sd1), .digits_o(dg1), .ctrl_o(ct1), .feature_o(ft1),
        .ext_clk_en_o(fl1[0]), .hex_decode_o(fl1[1]), .blink_en_o(fl1[2]),
        .blink_slow_o(fl1[3]), .blink_sync_o(fl1[4]), .blink_start_on_o(fl1[5])
    );

    // reference model, one entry per chained device
    logic [7:0]  m_dig  [2][8];
    logic [7:0]  m_ctl  [2][6];
    logic [7:0]  m_feat [2];
    logic [15:0] m_sr   [2];

    function automatic logic [7:0] ctl_def(int i);
        return (i == 2) ? 8'h07 : 8'h00;
    endfunction

    function automatic void m_reset();
        for (int d = 0; d < 2; d++) begin
            for (int k = 0; k < 8; k++) m_dig[d][k] = 8'h00;
            for (int k = 0; k < 6; k++) m_ctl[d][k] = ctl_def(k);
            m_feat[d] = 8'h00;
            m_sr[d]   = 16'h0000;
        end
    endfunction

    function automatic void m_apply(int d);
        logic [3:0] a;
        logic [7:0] v;
        a = m_sr[d][11:8];
        v = m_sr[d][7:0];
        if (a == 4'h0) return;
        if (a <= 4'h8) m_dig[d][a-1] = v;
        else if (a == 4'hE) begin
            m_feat[d] = v & 8'hF5;
            if (v[1]) for (int k = 0; k < 6; k++) m_ctl[d][k] = ctl_def(k);
        end else if (a == 4'hF) m_ctl[d][5] = v;
        else m_ctl[d][a-9] = v;
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_dev(int d, string req);
        logic [63:0] ed;
        logic [47:0] ec;
        logic [7:0]  f;
        for (int k = 0; k < 8; k++) ed[8*k +: 8] = m_dig[d][k];
        for (int k = 0; k < 6; k++) ec[8*k +: 8] = m_ctl[d][k];
        f = m_feat[d];
        chk(req, (d == 0) ? "dev0 digits" : "dev1 digits", (d == 0) ? dg0 : dg1, ed);
        chk(req, (d == 0) ? "dev0 ctrl" : "dev1 ctrl", 64'((d == 0) ? ct0 : ct1), 64'(ec));
        chk(req, (d == 0) ? "dev0 feature" : "dev1 feature", 64'((d == 0) ? ft0 : ft1), 64'(f));
        chk(req, (d == 0) ? "dev0 flags" : "dev1 flags", 64'((d == 0) ? fl0 : fl1),
            64'({f[7], f[6], f[5], f[4], f[2], f[0]}));
        chk(req, (d == 0) ? "dev0 sdout" : "dev1 sdout", 64'((d == 0) ? sd0 : sd1),
            64'(m_sr[d][15]));
    endtask

    task automatic send(logic [15:0] w);
        for (int i = 15; i >= 0; i--) begin
            @(negedge clk);
            sdin = w[i];
            sclk = 1'b0;
            repeat (2) @(negedge clk);
            sclk = 1'b1;
            repeat (2) @(negedge clk);
            sclk = 1'b0;
        end
        m_sr[1] = m_sr[0];
        m_sr[0] = w;
    endtask

    task automatic do_load();
        @(negedge clk);
        load = 1'b1;
        repeat (2) @(negedge clk);
        load = 1'b0;
        repeat (2) @(negedge clk);
        m_apply(0);
        m_apply(1);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [15:0] w;
        void'($urandom(32'd4711));
        rst_n = 1'b0; sclk = 1'b0; sdin = 1'b0; load = 1'b0;
        m_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_dev(0, "R1");
        check_dev(1, "R1");

        // R2: bits shift MSB first to sdout
        send(16'hA5C3);
        chk("R2", "sdout after word", 64'(sd0), 64'(1'b1));
        send(16'h0000);
        chk("R2", "far sdout carries near word", 64'(sd1), 64'(1'b1));
        check_dev(0, "R2");

        // R3: digit writes, upper nibble ignored
        for (int k = 1; k <= 8; k++) begin
            send({4'(k + 3), 4'(k), 8'(8'h10 * k + k)});
            do_load();
        end
        check_dev(0, "R3");
        send(16'hF35A);
        do_load();
        check_dev(0, "R3");

        // R4: control addresses
        send(16'h0911); do_load();
        send(16'h0A22); do_load();
        send(16'h0B33); do_load();
        send(16'h0C44); do_load();
        send(16'h0D55); do_load();
        send(16'h0F66); do_load();
        check_dev(0, "R4");

        // R5: no-op with noisy data
        send(16'h70FF);
        do_load();
        check_dev(0, "R5");

        // R6 / R7: feature all ones
        send(16'h0EFF);
        do_load();
        check_dev(0, "R6");
        chk("R7", "feature bits 1 and 3", 64'(ft0 & 8'h0A), 64'h0);

        // R8: register reset keeps digits and feature other bits
        send(16'h0B99); do_load();
        send(16'h0E16); do_load();
        check_dev(0, "R8");
        chk("R8", "scan default restored", 64'(ct0[23:16]), 64'h07);

        // R9: command for far device followed by a no-op
        send(16'h0833);
        send(16'h0000);
        do_load();
        chk("R9", "far digit7", 64'(dg1[63:56]), 64'h33);
        check_dev(0, "R9");
        check_dev(1, "R9");

        // random mix across the chain
        for (int n = 0; n < 120; n++) begin
            w = 16'($urandom);
            if (($urandom % 5) == 0) w[11:8] = 4'hE;
            if (($urandom % 6) == 0) w[11:8] = 4'h0;
            send(w);
            if (($urandom % 3) != 0) begin
                do_load();
                check_dev(0, "R3");
                check_dev(1, "R9");
            end
        end
        finish_run();
    end

endmodule